// File: doc/BRIEF.md
# ADC Register Interface with Deferred Channel and Reference Settings

This block is the byte-wide register front of an analog-to-digital converter. Software reaches it through a simple single-cycle write and combinational read bus. Through that bus it sets up the converter (enable, start, continuous mode, clock divider choice, interrupt enable) and chooses the input channel, the voltage reference and the alignment of the result. The conversion sequencer reports to this block when it is busy, when it begins a conversion and when a 10-bit result is ready. The block turns the stored settings into control levels for the sequencer and for the analog front end.

Channel and reference writes first land in a pending copy, which is what the bus reads back. They are moved into the active copy that drives the front end only while the sequencer is idle, or in the cycle that a conversion completes, so a conversion in flight never sees its input or reference change. The alignment bit is different: it changes how the stored result is shown on the two data bytes at once. When the reference selection changes, the block asks for the next conversion to be a long one. The active channel code is decoded into a single-ended or differential selection with a gain choice.

Top module: `adc_regfile`

## Requirements
- R1: After reset, reads of the result low byte (address 0x04), result high byte (0x05), control byte (0x06), channel byte (0x07) and any other address return 0x00, and `cfg_start`, `cfg_extend` and `irq` are 0.
- R2: The channel byte at 0x07 stores reference in bits 7:6, alignment in bit 5 and channel code in bits 2:0. Bits 4:3 read as 0 whatever value was written.
- R3: The control byte at 0x06 reads back enable (bit 7), start (bit 6), continuous mode (bit 5), done flag (bit 4), interrupt enable (bit 3) and divider select (bits 2:0). Writing 0 to bit 6 leaves the start bit unchanged.
- R4: Writing bit 6 = 1 together with bit 7 = 1 sets start. A completed conversion clears start when continuous mode is 0 and leaves it set when continuous mode is 1. Any write with bit 7 = 0 clears start, and a start request without enable does not set it.
- R5: A completed conversion sets the done flag. Writing 1 to bit 4 clears it and writing 0 leaves it alone. A completion in the same cycle as a clearing write leaves the flag set. `irq` equals flag AND interrupt enable.
- R6: Channel and reference values written while the sequencer is busy reach the front-end outputs only in the cycle after a conversion completes. While the sequencer is idle they reach those outputs one cycle after the write. The bus reads back the newly written value at once.
- R7: A change of the alignment bit changes the data-byte reads in the cycle after the write, even while a conversion is in progress.
- R8: The result is captured on completion. With alignment 0 the high byte is {6'b0, result[9:8]} and the low byte is result[7:0]. With alignment 1 the high byte is result[9:2] and the low byte is {result[1:0], 6'b0}.
- R9: A write to 0x07 whose bits 7:6 differ from the stored reference raises `cfg_extend`, which stays high until the sequencer's start pulse. A write that keeps the reference does not raise it.
- R10: Channel codes 0 to 3 give single-ended input equal to the code (`fe_diff`=0, `fe_neg`=0). Codes 4 and 5 give differential input 2 against input 2. Codes 6 and 7 give input 2 against input 3. `fe_gain20` is 1 for codes 5 and 7 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register address for read and write |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| seq_busy | input | 1 | Sequencer has a conversion in progress |
| seq_start | input | 1 | Pulse: sequencer begins a conversion |
| seq_done | input | 1 | Pulse: conversion complete, result valid |
| seq_result | input | 10 | Conversion result, valid with `seq_done` |
| cfg_enable | output | 1 | Converter enable |
| cfg_start | output | 1 | Start bit level to the sequencer |
| cfg_free_run | output | 1 | Continuous conversion mode |
| cfg_prescale | output | 3 | Clock divider select |
| cfg_extend | output | 1 | Next conversion must be the long form |
| irq | output | 1 | Completion interrupt request |
| fe_ref | output | 2 | Active reference selection |
| fe_diff | output | 1 | Active input is differential |
| fe_pos | output | 2 | Positive (or single) input index |
| fe_neg | output | 2 | Negative input index |
| fe_gain20 | output | 1 | Differential gain 20x when 1, 1x when 0 |

## Verification
On every cycle the assertions check that the active front-end settings hold still through a busy conversion with no completion, and that completion sets the flag, captures the result and, in single mode, drops the start bit. They also check that a reference change raises the extend request and that the reserved bits read as zero. Only the bench scenarios can show the values involved: the exact bytes seen for both alignments, the full channel decode table, the flag-clear race against completion, and that the pending settings reach the outputs one cycle after completion and not before.

// File: rtl/adc_rf_pkg.sv
package adc_rf_pkg;

  localparam int BYTE_W = 8;
  localparam int RES_W  = 10;
  localparam int CH_W   = 3;
  localparam int REF_W  = 2;
  localparam int PIN_W  = 2;

  typedef struct packed {
    logic             diff;
    logic [PIN_W-1:0] pos;
    logic [PIN_W-1:0] neg;
    logic             gain_hi;
  } fe_sel_t;

  // Decode a channel code into front-end routing.
  function automatic fe_sel_t decode_channel(input logic [CH_W-1:0] code);
    fe_sel_t s;
    s.diff    = code[CH_W-1];
    s.gain_hi = code[CH_W-1] & code[0];
    if (!code[CH_W-1]) begin
      s.pos = code[PIN_W-1:0];
      s.neg = '0;
    end else begin
      s.pos = PIN_W'(2);
      s.neg = code[1] ? PIN_W'(3) : PIN_W'(2);
    end
    return s;
  endfunction

  // Present the result on two bytes; left alignment packs it to the top.
  function automatic logic [2*BYTE_W-1:0] format_result(input logic [RES_W-1:0] res,
                                                       input logic left);
    logic [2*BYTE_W-1:0] wide;
    wide = (2*BYTE_W)'(res);
    if (left) wide = wide << (2*BYTE_W - RES_W);
    return wide;
  endfunction

endpackage

// File: rtl/adc_rf_ctrl.sv
module adc_rf_ctrl
  import adc_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              seq_done,
  output logic [BYTE_W-1:0] ctrl_rd,
  output logic              enable,
  output logic              start,
  output logic              free_run,
  output logic [2:0]        prescale,
  output logic              irq
);

  logic       en_q, start_q, free_q, flag_q, ie_q;
  logic [2:0] presc_q;
  logic       start_d, flag_d;

  // Named events for the assertions
  logic wr_enable_bit, wr_start_bit, wr_flag_bit;
  assign wr_enable_bit = wdata[7];
  assign wr_start_bit  = wdata[6];
  assign wr_flag_bit   = wdata[4];

  always_comb begin
    start_d = start_q;
    if (seq_done && !free_q) start_d = 1'b0;
    if (wr_sel && wr_start_bit) start_d = 1'b1;
    if (wr_sel && !wr_enable_bit) start_d = 1'b0;
    flag_d = flag_q;
    if (wr_sel && wr_flag_bit) flag_d = 1'b0;
    if (seq_done) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      start_q <= 1'b0;
      free_q  <= 1'b0;
      flag_q  <= 1'b0;
      ie_q    <= 1'b0;
      presc_q <= '0;
    end else begin
      start_q <= start_d;
      flag_q  <= flag_d;
      if (wr_sel) begin
        en_q    <= wdata[7];
        free_q  <= wdata[5];
        ie_q    <= wdata[3];
        presc_q <= wdata[2:0];
      end
    end
  end

  assign ctrl_rd  = {en_q, start_q, free_q, flag_q, ie_q, presc_q};
  assign enable   = en_q;
  assign start    = start_q;
  assign free_run = free_q;
  assign prescale = presc_q;
  assign irq      = flag_q & ie_q;

  assert_done_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> flag_q);

  assert_single_done_clears_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && !free_q && !wr_sel) |=> !start_q);

  assert_disable_drops_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !wr_enable_bit) |=> !start_q);

  assert_zero_start_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && wr_enable_bit && !wr_start_bit && !seq_done) |=> start_q == $past(start_q));

endmodule

// File: rtl/adc_rf_cfg.sv
module adc_rf_cfg
  import adc_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              seq_busy,
  input  logic              seq_start,
  input  logic              seq_done,
  output logic [BYTE_W-1:0] mux_rd,
  output logic              left_align,
  output logic [REF_W-1:0]  act_ref,
  output logic [CH_W-1:0]   act_ch,
  output logic              extend
);

  logic [REF_W-1:0] ref_pend;
  logic [CH_W-1:0]  ch_pend;
  logic             left_q;
  logic             ext_q;

  // Named events for the assertions
  logic ref_change, may_load;
  assign ref_change = wr_sel && (wdata[7:6] != ref_pend);
  assign may_load   = !seq_busy || seq_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_pend <= '0;
      ch_pend  <= '0;
      left_q   <= 1'b0;
      act_ref  <= '0;
      act_ch   <= '0;
      ext_q    <= 1'b0;
    end else begin
      if (wr_sel) begin
        ref_pend <= wdata[7:6];
        left_q   <= wdata[5];
        ch_pend  <= wdata[CH_W-1:0];
      end
      if (may_load) begin
        act_ref <= ref_pend;
        act_ch  <= ch_pend;
      end
      if (ref_change)     ext_q <= 1'b1;
      else if (seq_start) ext_q <= 1'b0;
    end
  end

  assign mux_rd     = {ref_pend, left_q, 2'b00, ch_pend};
  assign left_align = left_q;
  assign extend     = ext_q;

  assert_active_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && !seq_done) |=> $stable({act_ref, act_ch}));

  assert_ref_change_extends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_change |=> extend);

  assert_start_ends_extend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_start && !wr_sel) |=> !extend);

endmodule

// File: rtl/adc_rf_result.sv
module adc_rf_result
  import adc_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_done,
  input  logic [RES_W-1:0]  seq_result,
  input  logic              left_align,
  output logic [BYTE_W-1:0] data_hi,
  output logic [BYTE_W-1:0] data_lo
);

  logic [RES_W-1:0]    res_q;
  logic [2*BYTE_W-1:0] view;

  always_ff @(posedge clk) begin
    if (!rst_n) res_q <= '0;
    else if (seq_done) res_q <= seq_result;
  end

  assign view    = format_result(res_q, left_align);
  assign data_hi = view[2*BYTE_W-1:BYTE_W];
  assign data_lo = view[BYTE_W-1:0];

  assert_result_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> res_q == $past(seq_result));

  assert_right_high_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !left_align |-> data_hi[BYTE_W-1:RES_W-BYTE_W] == '0);

endmodule

// File: rtl/adc_regfile.sv
module adc_regfile
  import adc_rf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] DLO_ADDR  = 6'h04,
  parameter logic [ADDR_W-1:0] DHI_ADDR  = 6'h05,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h06,
  parameter logic [ADDR_W-1:0] MUX_ADDR  = 6'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              seq_busy,
  input  logic              seq_start,
  input  logic              seq_done,
  input  logic [9:0]        seq_result,
  output logic              cfg_enable,
  output logic              cfg_start,
  output logic              cfg_free_run,
  output logic [2:0]        cfg_prescale,
  output logic              cfg_extend,
  output logic              irq,
  output logic [1:0]        fe_ref,
  output logic              fe_diff,
  output logic [1:0]        fe_pos,
  output logic [1:0]        fe_neg,
  output logic              fe_gain20
);

  logic              ctrl_wr, mux_wr;
  logic [BYTE_W-1:0] ctrl_rd, mux_rd, data_hi, data_lo;
  logic              left_align;
  logic [REF_W-1:0]  act_ref;
  logic [CH_W-1:0]   act_ch;
  fe_sel_t           fe_sel;

  assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);
  assign mux_wr  = bus_wr && (bus_addr == MUX_ADDR);

  adc_rf_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_sel   (ctrl_wr),
    .wdata    (bus_wdata),
    .seq_done (seq_done),
    .ctrl_rd  (ctrl_rd),
    .enable   (cfg_enable),
    .start    (cfg_start),
    .free_run (cfg_free_run),
    .prescale (cfg_prescale),
    .irq      (irq)
  );

  adc_rf_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_sel     (mux_wr),
    .wdata      (bus_wdata),
    .seq_busy   (seq_busy),
    .seq_start  (seq_start),
    .seq_done   (seq_done),
    .mux_rd     (mux_rd),
    .left_align (left_align),
    .act_ref    (act_ref),
    .act_ch     (act_ch),
    .extend     (cfg_extend)
  );

  adc_rf_result u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .seq_done   (seq_done),
    .seq_result (seq_result),
    .left_align (left_align),
    .data_hi    (data_hi),
    .data_lo    (data_lo)
  );

  assign fe_sel    = decode_channel(act_ch);
  assign fe_ref    = act_ref;
  assign fe_diff   = fe_sel.diff;
  assign fe_pos    = fe_sel.pos;
  assign fe_neg    = fe_sel.neg;
  assign fe_gain20 = fe_sel.gain_hi;

  always_comb begin
    unique case (bus_addr)
      CTRL_ADDR: bus_rdata = ctrl_rd;
      MUX_ADDR:  bus_rdata = mux_rd;
      DHI_ADDR:  bus_rdata = data_hi;
      DLO_ADDR:  bus_rdata = data_lo;
      default:   bus_rdata = '0;
    endcase
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == MUX_ADDR) |-> bus_rdata[4:3] == 2'b00);

  assert_single_input_routing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fe_diff |-> (fe_neg == 2'b00 && !fe_gain20));

endmodule

// File: tb/sim_adc_regfile.sv
module sim_adc_regfile;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       seq_busy = 1'b0, seq_start = 1'b0, seq_done = 1'b0;
  logic [9:0] seq_result = '0;
  logic       cfg_enable, cfg_start, cfg_free_run, cfg_extend, irq;
  logic [2:0] cfg_prescale;
  logic [1:0] fe_ref, fe_pos, fe_neg;
  logic       fe_diff, fe_gain20;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  adc_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seq_busy(seq_busy),
    .seq_start(seq_start), .seq_done(seq_done), .seq_result(seq_result),
    .cfg_enable(cfg_enable), .cfg_start(cfg_start), .cfg_free_run(cfg_free_run),
    .cfg_prescale(cfg_prescale), .cfg_extend(cfg_extend), .irq(irq),
    .fe_ref(fe_ref), .fe_diff(fe_diff), .fe_pos(fe_pos), .fe_neg(fe_neg),
    .fe_gain20(fe_gain20)
  );

  // Scoreboard items: kind 0 read data, 1 start, 2 extend, 3 irq, 4 front end, 5 enable
  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb[$];

  function automatic logic [7:0] observe(int kind);
    case (kind)
      0: return bus_rdata;
      1: return {7'b0, cfg_start};
      2: return {7'b0, cfg_extend};
      3: return {7'b0, irq};
      4: return {fe_ref, fe_diff, fe_pos, fe_neg, fe_gain20};
      default: return {7'b0, cfg_enable};
    endcase
  endfunction

  // Monitor: pops expectations and compares them with the outputs
  initial begin
    forever begin
      item_t it;
      logic [7:0] act;
      wait (sb.size() != 0);
      it = sb.pop_front();
      act = observe(it.kind);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push_rd(input logic [5:0] a, input logic [7:0] e, input string r);
    item_t it;
    bus_addr = a;
    #1;
    it.kind = 0; it.exp = e; it.req = r;
    sb.push_back(it);
    #0;
  endtask

  task automatic push_sig(input int k, input logic [7:0] e, input string r);
    item_t it;
    #1;
    it.kind = k; it.exp = e; it.req = r;
    sb.push_back(it);
    #0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    tick();
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic complete(input logic [9:0] r);
    tick();
    seq_done = 1'b1; seq_result = r;
    tick();
    seq_done = 1'b0;
  endtask

  task automatic start_pulse();
    tick();
    seq_start = 1'b1;
    tick();
    seq_start = 1'b0;
  endtask

  // Expected front-end byte {ref, diff, pos, neg, gain}, worked out per code
  function automatic logic [7:0] fe_expect(input logic [1:0] rf, input logic [2:0] code);
    logic d, g;
    logic [1:0] p, n;
    d = (code >= 3'd4);
    p = d ? 2'd2 : code[1:0];
    n = (code >= 3'd6) ? 2'd3 : (d ? 2'd2 : 2'd0);
    g = (code == 3'd5) || (code == 3'd7);
    return {rf, d, p, n, g};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    push_rd(6'h04, 8'h00, "R1 low byte");
    push_rd(6'h05, 8'h00, "R1 high byte");
    push_rd(6'h06, 8'h00, "R1 control");
    push_rd(6'h07, 8'h00, "R1 channel");
    push_rd(6'h00, 8'h00, "R1 unmapped");
    push_sig(1, 8'h00, "R1 start");
    push_sig(2, 8'h00, "R1 extend");
    push_sig(3, 8'h00, "R1 irq");

    // R2 reserved bits, R9 extend on reference change
    wr(6'h07, 8'hFF);
    push_rd(6'h07, 8'hE7, "R2 reserved bits read zero");
    push_sig(2, 8'h01, "R9 extend after reference change");
    tick();
    push_sig(4, fe_expect(2'd3, 3'd7), "R6 idle load");
    start_pulse();
    push_sig(2, 8'h00, "R9 extend cleared by start");
    wr(6'h07, 8'hC7);
    push_sig(2, 8'h00, "R9 same reference no extend");
    push_rd(6'h07, 8'hC7, "R2 readback");

    // R10 channel decode
    for (int c = 0; c < 8; c++) begin
      wr(6'h07, {2'b11, 3'b000, 3'(c)});
      tick();
      push_sig(4, fe_expect(2'd3, 3'(c)), "R10 channel decode");
    end
    wr(6'h07, 8'hC7);
    tick();

    // R3 / R4 control byte and start bit
    wr(6'h06, 8'h8B);
    push_rd(6'h06, 8'h8B, "R3 control readback");
    push_sig(5, 8'h01, "R3 enable");
    push_sig(1, 8'h00, "R4 no start yet");
    wr(6'h06, 8'hCB);
    push_rd(6'h06, 8'hCB, "R4 start set");
    push_sig(1, 8'h01, "R4 start output");
    wr(6'h06, 8'h8B);
    push_rd(6'h06, 8'hCB, "R3 zero to start no effect");
    complete(10'h2A5);
    push_rd(6'h06, 8'h9B, "R4 single mode clears start, R5 flag set");
    push_sig(1, 8'h00, "R4 start cleared");
    push_sig(3, 8'h01, "R5 irq raised");

    // R5 flag clear rules
    wr(6'h06, 8'h8B);
    push_rd(6'h06, 8'h9B, "R5 writing zero keeps flag");
    wr(6'h06, 8'h9B);
    push_rd(6'h06, 8'h8B, "R5 writing one clears flag");
    push_sig(3, 8'h00, "R5 irq dropped");
    tick();
    bus_addr = 6'h06; bus_wdata = 8'h9B; bus_wr = 1'b1;
    seq_done = 1'b1; seq_result = 10'h2A5;
    tick();
    bus_wr = 1'b0; seq_done = 1'b0;
    push_rd(6'h06, 8'h9B, "R5 completion wins over clear");
    wr(6'h06, 8'h9B);

    // R8 formatting, R7 immediate alignment
    push_rd(6'h05, 8'h02, "R8 right high");
    push_rd(6'h04, 8'hA5, "R8 right low");
    wr(6'h07, 8'hE7);
    push_rd(6'h05, 8'hA9, "R8 left high");
    push_rd(6'h04, 8'h40, "R8 left low");
    seq_busy = 1'b1;
    wr(6'h07, 8'hC7);
    push_rd(6'h05, 8'h02, "R7 alignment applies during conversion");

    // R6 deferral while busy
    wr(6'h07, 8'h01);
    push_rd(6'h07, 8'h01, "R6 pending readback");
    push_sig(2, 8'h01, "R9 extend on deferred reference change");
    repeat (3) tick();
    push_sig(4, fe_expect(2'd3, 3'd7), "R6 held during conversion");
    complete(10'h0FF);
    push_sig(4, fe_expect(2'd0, 3'd1), "R6 applied after completion");
    push_rd(6'h05, 8'h00, "R8 right high second result");
    push_rd(6'h04, 8'hFF, "R8 right low second result");
    seq_busy = 1'b0;
    start_pulse();
    push_sig(2, 8'h00, "R9 extend cleared");

    // R4 continuous mode and enable clear
    wr(6'h06, 8'hFB);
    push_rd(6'h06, 8'hEB, "R4 continuous start");
    complete(10'h3FF);
    push_rd(6'h06, 8'hFB, "R4 continuous keeps start");
    push_sig(1, 8'h01, "R4 start held");
    wr(6'h06, 8'h08);
    push_rd(6'h06, 8'h18, "R4 disable clears start");
    push_sig(1, 8'h00, "R4 start off");
    push_sig(5, 8'h00, "R4 enable off");
    wr(6'h06, 8'h48);
    push_rd(6'h06, 8'h18, "R4 start needs enable");
    push_rd(6'h05, 8'h03, "R8 full scale high");

    wait (sb.size() == 0);
    tick();
    done_flag = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule